// File: doc/BRIEF.md
# SDRAM Data-Lane Timing Pipeline

This block sits on the data side of a 32-bit single-data-rate SDRAM port. It handles only the timing of the data bus. It delays each read beat by the programmed CAS latency of 2 or 3 clocks, so the beat lines up with the clock in which the data is on the bus. It applies the four byte-mask inputs with two different latencies: a write sees its mask in the same clock, and a read sees its mask two clocks later. It also cuts the read stream short when a burst-stop or precharge event arrives.

Command decoding and the memory array sit outside this block. A command sequencer drives one read strobe per column read beat and one write strobe per write beat. With each read strobe it supplies the word the array returns. It raises a stop input when it issues a burst stop or a precharge. The block returns four outputs:

- per-lane write enables;
- a read-valid flag;
- per-lane output enables;
- the aligned read word, with disabled lanes forced to zero.

Top module: `sdram_dq_timing`

## Requirements
- R1: In every clock, `wr_be[i]` is high exactly when `wr_beat` is high and `dqm[i]` is low in that same clock. There is no register delay: write latency and write-mask latency are both zero.
- R2: Mask bit `dqm[i]`, write enable `wr_be[i]` and output enable `rd_oe[i]` all govern byte lane i, which is data bits 8i+7 down to 8i. Bit 0 maps to bits 7:0, bit 1 to 15:8, bit 2 to 23:16 and bit 3 to 31:24.
- R3: A read beat accepted at clock edge t makes `rd_valid` high, and presents the `rd_data_in` word sampled at edge t, in the clock period that ends at edge t+L. Here L is 3 when `cl3` is 1 and 2 when `cl3` is 0.
- R4: A mask bit sampled high at clock edge t disables its lane's read output in the clock period that ends at edge t+2, whatever the CAS latency.
- R5: `rd_oe[i]` equals `rd_valid` AND the inverse of the read-delayed mask bit i. `rd_dq` carries the aligned read word on enabled lanes and zero on disabled lanes. `rd_dq` is all zero when `rd_valid` is low.
- R6: A read beat sampled in the same edge as `stop_evt` is discarded. So is every read beat that follows it without a gap. Beats accepted before the stop still come out, so the read outputs go inactive L clocks after the stop event.
- R7: A clock with `rd_beat` low ends the discard started by a stop event. A read beat after that gap is accepted normally.
- R8: While `rst_n` is low, `rd_valid`, `rd_oe` and `rd_dq` are zero, even if `rd_beat` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl3 | input | 1 | CAS latency select: 1 gives 3 clocks, 0 gives 2 clocks |
| rd_beat | input | 1 | One column read beat issued this clock |
| wr_beat | input | 1 | One write beat on the bus this clock |
| stop_evt | input | 1 | Burst stop or precharge issued this clock |
| dqm | input | 4 | Per-lane mask, high masks the lane |
| rd_data_in | input | 32 | Word returned by the array for this read beat |
| wr_be | output | 4 | Per-lane write enable for the current clock |
| rd_valid | output | 1 | Read data is on the bus this clock |
| rd_oe | output | 4 | Per-lane output enable |
| rd_dq | output | 32 | Aligned read word, disabled lanes zero |

## Verification

The bench uses several kinds of stimulus, and each one exposes a different kind of fault:

- **Write beats under every mask value.** These separate zero-latency masking from any registered version, and show a swapped lane mapping.
- **Read bursts at both latencies, with the mask changing every clock.** These show whether the valid delay follows `cl3`. They also show whether the read mask uses its own fixed two-clock delay or is wrongly tied to the CAS latency.
- **Stop events mid-burst at each latency, followed by a gap and a new burst.** These separate correct truncation from truncation that is early, late or never released.
- **A long pseudo-random mix of all inputs, with the latency switching.** This catches interactions between the other cases.

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cl3,
  input  logic                    rd_beat,
  input  logic                    wr_beat,
  input  logic                    stop_evt,
  input  logic [LANES-1:0]        dqm,
  input  logic [LANES*LANE_W-1:0] rd_data_in,
  output logic [LANES-1:0]        wr_be,
  output logic                    rd_valid,
  output logic [LANES-1:0]        rd_oe,
  output logic [LANES*LANE_W-1:0] rd_dq
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 3;
  localparam int MLAT  = 2;

  logic             blk_q;
  logic             kill;
  logic             take;
  logic [DEPTH-1:0] vpipe;
  logic [DW-1:0]    dpipe [DEPTH];
  logic [LANES-1:0] mpipe [MLAT];
  logic [DW-1:0]    dsel;

  assign kill = stop_evt | blk_q;
  assign take = rd_beat & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      vpipe <= '0;
    end else begin
      blk_q <= rd_beat & kill;
      vpipe <= {vpipe[DEPTH-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dpipe[i] <= '0;
    end else begin
      dpipe[0] <= rd_data_in;
      for (int i = 1; i < DEPTH; i++) dpipe[i] <= dpipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MLAT; i++) mpipe[i] <= '0;
    end else begin
      mpipe[0] <= dqm;
      for (int i = 1; i < MLAT; i++) mpipe[i] <= mpipe[i-1];
    end
  end

  assign rd_valid = cl3 ? vpipe[2] : vpipe[1];
  assign dsel     = cl3 ? dpipe[2] : dpipe[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_be[g] = wr_beat & ~dqm[g];
    assign rd_oe[g] = rd_valid & ~mpipe[MLAT-1][g];
    assign rd_dq[g*LANE_W +: LANE_W] = rd_oe[g] ? dsel[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sdram_dq_timing_chk.sv
module sdram_dq_timing_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cl3,
  input logic        rd_beat,
  input logic        wr_beat,
  input logic        stop_evt,
  input logic [3:0]  dqm,
  input logic [3:0]  wr_be,
  input logic        rd_valid,
  input logic [3:0]  rd_oe,
  input logic [31:0] rd_dq
);
  a_r1_idle_no_be: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_beat |-> wr_be == 4'b0);

  a_r1_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_be & dqm) == 4'b0);

  a_r3_cl3_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && rd_valid) |-> $past(rd_beat, 3));

  a_r3_cl2_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3 && rd_valid) |-> $past(rd_beat, 2));

  a_r4_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe & $past(dqm, 2)) == 4'b0);

  a_r5_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_oe == 4'b0 && rd_dq == 32'b0));

  a_r6_stop_cl3: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && $past(stop_evt, 3)) |-> !rd_valid);

  a_r6_stop_cl2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3 && $past(stop_evt, 2)) |-> !rd_valid);
endmodule

bind sdram_dq_timing sdram_dq_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cl3(cl3), .rd_beat(rd_beat), .wr_beat(wr_beat),
  .stop_evt(stop_evt), .dqm(dqm), .wr_be(wr_be), .rd_valid(rd_valid),
  .rd_oe(rd_oe), .rd_dq(rd_dq)
);

// File: tb/sdram_dq_timing_tb.sv
module sdram_dq_timing_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HIST = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cl3 = 1'b0;
  logic        rd_beat = 1'b0;
  logic        wr_beat = 1'b0;
  logic        stop_evt = 1'b0;
  logic [3:0]  dqm = 4'b0;
  logic [31:0] rd_data_in = 32'b0;
  logic [3:0]  wr_be;
  logic        rd_valid;
  logic [3:0]  rd_oe;
  logic [31:0] rd_dq;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int cycles = 0;
  bit blk = 1'b0;
  int unsigned seed = 32'h1234_5678;

  bit          eff_h [HIST];
  logic [31:0] din_h [HIST];
  logic [3:0]  dqm_h [HIST];

  sdram_dq_timing u_dut (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .rd_beat(rd_beat), .wr_beat(wr_beat),
    .stop_evt(stop_evt), .dqm(dqm), .rd_data_in(rd_data_in), .wr_be(wr_be),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .rd_dq(rd_dq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at step %0d actual %h expected %h", tag, k, act, exp);
    end
  endtask

  task automatic check_regs();
    int lat;
    int idx;
    bit v;
    logic [3:0] m;
    logic [3:0] oe;
    logic [31:0] d;
    lat = cl3 ? 3 : 2;
    idx = k - lat + 1;
    v = (idx >= 1) ? eff_h[idx] : 1'b0;
    m = (k - 1 >= 1) ? dqm_h[k-1] : 4'b0;
    oe = v ? ~m : 4'b0;
    d = 32'b0;
    for (int i = 0; i < 4; i++)
      if (oe[i]) d[i*8 +: 8] = din_h[idx][i*8 +: 8];
    chk("R3 R6 R7 rd_valid", {31'b0, rd_valid}, {31'b0, v});
    chk("R4 R5 rd_oe", {28'b0, rd_oe}, {28'b0, oe});
    chk("R2 R3 R5 rd_dq", rd_dq, d);
  endtask

  task automatic cyc(input bit c3, input bit rd, input bit wr, input logic [3:0] m,
                     input bit h, input logic [31:0] d);
    bit blocking;
    bit e;
    cl3 = c3;
    #1;
    check_regs();
    rd_beat = rd; wr_beat = wr; dqm = m; stop_evt = h; rd_data_in = d;
    #1;
    chk("R1 R2 wr_be", {28'b0, wr_be}, {28'b0, wr ? ~m : 4'b0});
    blocking = h | blk;
    e = rd & !blocking;
    blk = rd & blocking;
    eff_h[k+1] = e; din_h[k+1] = d; dqm_h[k+1] = m;
    @(negedge clk);
    k++;
  endtask

  function automatic logic [31:0] dv(input int n);
    return n * 32'h9E37_79B1 + 32'h0F1E_2D3C;
  endfunction

  task automatic idle(input bit c3, input int n);
    for (int i = 0; i < n; i++) cyc(c3, 0, 0, 4'b0, 0, 32'b0);
  endtask

  task automatic burst(input bit c3, input int len, input int stop_at, input logic [3:0] mstart);
    for (int i = 0; i < len; i++)
      cyc(c3, 1, 0, mstart + 4'(i), (i == stop_at), dv(k));
  endtask

  initial begin
    for (int i = 0; i < HIST; i++) begin eff_h[i] = 0; din_h[i] = 0; dqm_h[i] = 0; end
    rd_beat = 1'b1;
    rd_data_in = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk("R8 reset rd_valid", {31'b0, rd_valid}, 32'b0);
    chk("R8 reset rd_oe", {28'b0, rd_oe}, 32'b0);
    chk("R8 reset rd_dq", rd_dq, 32'b0);
    rd_beat = 1'b0;
    rd_data_in = 32'b0;
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;

    // R1 R2: writes under every mask value, then masks without a write beat
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 4'(i), 0, 32'b0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 4'(i * 5), 0, 32'b0);

    // R3 R4 R5: read bursts at both latencies with changing masks
    burst(0, 4, -1, 4'd0); idle(0, 5);
    burst(1, 4, -1, 4'd6); idle(1, 5);
    burst(0, 8, -1, 4'd8); idle(0, 5);
    burst(1, 8, -1, 4'd3); idle(1, 5);

    // R6: stop mid-burst, strobes continue
    burst(0, 8, 3, 4'd0); idle(0, 5);
    burst(1, 8, 3, 4'd0); idle(1, 5);
    burst(1, 6, 0, 4'd2); idle(1, 5);

    // R7: stop, gap, then a new burst
    burst(0, 4, 1, 4'd0);
    cyc(0, 0, 0, 4'b0, 0, 32'b0);
    burst(0, 4, -1, 4'd1); idle(0, 5);
    burst(1, 4, 2, 4'd0);
    cyc(1, 0, 0, 4'b0, 0, 32'b0);
    burst(1, 4, -1, 4'd9); idle(1, 5);

    // mixed pseudo-random traffic, latency switching
    for (int i = 0; i < 600; i++) begin
      bit c3;
      seed = seed * 32'd1664525 + 32'd1013904223;
      c3 = (i / 150) % 2 == 1;
      cyc(c3, seed[20] | seed[21], seed[22] & seed[23], seed[27:24],
          seed[17] & seed[18] & seed[19], dv(k));
    end
    idle(0, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule